// File: doc/BRIEF.md
# Queued ADC Scan Sequencer

This block runs a programmable queue of conversion commands for a multi-channel analog-to-digital converter in continuous scan mode. Each queue entry is one byte: bits [5:0] hold a channel number and bits [7:6] an input sample-time code. Scanning starts at entry 0. For each entry the block resolves the channel number into a conversion source: an external pin, or one of three references. It holds a sample phase when the source needs one. It then starts the conversion engine and waits for its done pulse. It stores the 10-bit value, justified into one of three 16-bit formats, in the result register with the same index as the entry.

The conversion engine is a purely digital partner. It receives a one-cycle `convStart` pulse carrying a source kind and a channel number. Some cycles later it answers with a one-cycle `convDone` pulse and the raw 10-bit value. A single-port command write path loads queue entries. A combinational read port returns any result register. When a pass of the queue ends, the next pass begins at once, so every result register holds the latest value for its entry.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset every result register reads 0x0000 and every queue entry holds channel 63, so enabling the scan issues no conversion.
- R2: An entry whose channel is 63 gets no conversion. While `scanEn` is high, reaching it restarts the scan at entry 0 without a pause.
- R3: A queue with no channel-63 entry proceeds from its last entry (index QDEPTH-1) to entry 0.
- R4: Channels 60, 61 and 62 are internal. They start a conversion with no sample phase, and `convKind` is 1 (low reference), 2 (high reference) or 3 (mid scale) respectively.
- R5: Channels 32 to 47 are reserved. They convert with `convKind` 1 (low reference) and still go through the sample phase.
- R6: With `muxMode` low, channels 0–3 and 48–59 are pins (`convKind` 0, `convChan` equal to the channel) and channels 4–31 convert as `convKind` 1. With `muxMode` high, channels 0–31 are also pins.
- R7: For channels that are not internal, `sampleActive` stays high for 2, 4, 8 or 16 cycles for sample-time codes 0, 1, 2 or 3. `convStart` follows in the next cycle.
- R8: `justMode` selects the stored format of raw value d. Code 0 and code 3 give right-justified unsigned {6'b0,d}. Code 1 gives left-justified signed {~d[9],d[8:0],6'b0}, in which half scale reads as zero. Code 2 gives left-justified unsigned {d,6'b0}.
- R9: While a pin with channel below 32 is selected in multiplexed mode, `muxSel` equals channel bits [2:0]. Otherwise `muxSel` is 0, and it is always 0 when `muxMode` is low.
- R10: `convStart` lasts exactly one cycle. The result for a `convDone` becomes visible on `rdData` in the cycle after the done pulse, and in the done cycle itself `rdData` still shows the previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| scanEn | input | 1 | Run continuous scanning while high |
| muxMode | input | 1 | 1 = external demultiplexer mode, 0 = direct mode |
| justMode | input | 2 | Result format code (see R8) |
| cmdWrEn | input | 1 | Write strobe for a queue entry |
| cmdWrAddr | input | IDX_W | Queue entry index to write |
| cmdWrData | input | 8 | Entry: [7:6] sample-time code, [5:0] channel |
| rdAddr | input | IDX_W | Result register index to read |
| rdData | output | 16 | Result register contents |
| sampleActive | output | 1 | Sample phase in progress |
| muxSel | output | 3 | External demultiplexer select lines |
| convStart | output | 1 | One-cycle conversion request |
| convKind | output | 2 | Source: 0 pin, 1 low ref, 2 high ref, 3 mid scale |
| convChan | output | 6 | Pin channel number when convKind is 0, else 0 |
| convDone | input | 1 | One-cycle completion from the engine |
| convData | input | 10 | Raw conversion value, valid with convDone |

## Verification
A completed conversion writes its result register in the same cycle that the consumer may be reading that register. The two must not be confused. The bench keeps the read address fixed on entry 0 and changes the justification code while the scan runs. It then waits for the done pulse that belongs to entry 0. In that done cycle it expects the old format on `rdData`, and in the next cycle the new one. The queue restart at an end marker and the index wrap also occur in a single cycle. The bench judges them from the order of the channels the engine sees.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_HIGH = 2'd2,
    SRC_MID  = 2'd3
  } srcKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleOn;
    logic startConv;
    logic writeResult;
  } seqStrobe_t;

  localparam logic [5:0] CHAN_EOQ = 6'd63;

  function automatic srcKind_e resolveSrc(input logic [5:0] chan, input logic muxed);
    srcKind_e k;
    if (chan == 6'd60)                           k = SRC_LOW;
    else if (chan == 6'd61)                      k = SRC_HIGH;
    else if (chan == 6'd62)                      k = SRC_MID;
    else if (chan >= 6'd48)                      k = SRC_PIN;   // 48..59 direct pins
    else if (chan >= 6'd32)                      k = SRC_LOW;   // reserved
    else if (chan <= 6'd3 || muxed)              k = SRC_PIN;
    else                                         k = SRC_LOW;   // invalid in direct mode
    return k;
  endfunction

endpackage

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int QDEPTH = 64,
  parameter int RAW_W  = 10,
  parameter int RES_W  = 16,
  localparam int IDX_W = $clog2(QDEPTH),
  localparam int PAD_W = RES_W - RAW_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             muxMode,
  input  logic [1:0]       justMode,
  input  logic             cmdWrEn,
  input  logic [IDX_W-1:0] cmdWrAddr,
  input  logic [7:0]       cmdWrData,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [RES_W-1:0] rdData,
  input  logic [IDX_W-1:0] curIdx,
  input  seqStrobe_t       strobe,
  output logic             entryEoq,
  output logic             entryInternal,
  output logic [1:0]       entrySampleCode,
  output logic [1:0]       convKind,
  output logic [5:0]       convChan,
  output logic [2:0]       muxSel,
  input  logic [RAW_W-1:0] convData
);

  logic [7:0]       queueMem [QDEPTH];
  logic [RES_W-1:0] resultMem [QDEPTH];
  logic [7:0]       curEntry;
  logic [5:0]       curChan;
  srcKind_e         curKind;
  logic [RES_W-1:0] justified;

  assign curEntry        = queueMem[curIdx];
  assign curChan         = curEntry[5:0];
  assign entrySampleCode = curEntry[7:6];
  assign curKind         = resolveSrc(curChan, muxMode);
  assign entryEoq        = (curChan == CHAN_EOQ);
  assign entryInternal   = (curChan >= 6'd60) && (curChan <= 6'd62);

  assign convKind = curKind;
  assign convChan = (curKind == SRC_PIN) ? curChan : 6'd0;
  assign muxSel   = (muxMode && curKind == SRC_PIN && curChan < 6'd32) ? curChan[2:0] : 3'd0;

  always_comb begin
    case (justMode)
      2'd1:    justified = {~convData[RAW_W-1], convData[RAW_W-2:0], {PAD_W{1'b0}}};
      2'd2:    justified = {convData, {PAD_W{1'b0}}};
      default: justified = {{PAD_W{1'b0}}, convData};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < QDEPTH; i++) queueMem[i] <= {2'b00, CHAN_EOQ};
    end else if (cmdWrEn) begin
      queueMem[cmdWrAddr] <= cmdWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < QDEPTH; i++) resultMem[i] <= '0;
    end else if (strobe.writeResult) begin
      resultMem[curIdx] <= justified;
    end
  end

  assign rdData = resultMem[rdAddr];

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int QDEPTH = 64,
  localparam int IDX_W = $clog2(QDEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanEn,
  input  logic             entryEoq,
  input  logic             entryInternal,
  input  logic [1:0]       entrySampleCode,
  input  logic             convDone,
  output logic [IDX_W-1:0] curIdx,
  output seqStrobe_t       strobe
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SAMPLE, S_START, S_WAIT} seqState_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(QDEPTH - 1);

  seqState_e  state;
  logic [3:0] sampleCnt;

  assign strobe.sampleOn    = (state == S_SAMPLE);
  assign strobe.startConv   = (state == S_START);
  assign strobe.writeResult = (state == S_WAIT) && convDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      curIdx    <= '0;
      sampleCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          curIdx <= '0;
          if (scanEn) state <= S_FETCH;
        end
        S_FETCH: begin
          if (!scanEn) begin
            state <= S_IDLE;
          end else if (entryEoq) begin
            curIdx <= '0;
          end else if (entryInternal) begin
            state <= S_START;
          end else begin
            sampleCnt <= 4'((5'd2 << entrySampleCode) - 5'd1);
            state     <= S_SAMPLE;
          end
        end
        S_SAMPLE: begin
          if (sampleCnt == 4'd0) state <= S_START;
          else sampleCnt <= sampleCnt - 4'd1;
        end
        S_START: state <= S_WAIT;
        S_WAIT: begin
          if (convDone) begin
            curIdx <= (curIdx == LAST_IDX) ? '0 : curIdx + 1'b1;
            state  <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import scan_pkg::*;
#(
  parameter int QDEPTH = 64,
  localparam int IDX_W = $clog2(QDEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scanEn,
  input  logic             muxMode,
  input  logic [1:0]       justMode,
  input  logic             cmdWrEn,
  input  logic [IDX_W-1:0] cmdWrAddr,
  input  logic [7:0]       cmdWrData,
  input  logic [IDX_W-1:0] rdAddr,
  output logic [15:0]      rdData,
  output logic             sampleActive,
  output logic [2:0]       muxSel,
  output logic             convStart,
  output logic [1:0]       convKind,
  output logic [5:0]       convChan,
  input  logic             convDone,
  input  logic [9:0]       convData
);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] curIdx;
  logic             entryEoq;
  logic             entryInternal;
  logic [1:0]       entrySampleCode;

  scan_ctrl #(.QDEPTH(QDEPTH)) ctrl (
    .clk, .rstN, .scanEn, .entryEoq, .entryInternal, .entrySampleCode,
    .convDone, .curIdx, .strobe
  );

  scan_datapath #(.QDEPTH(QDEPTH), .RAW_W(10), .RES_W(16)) dpath (
    .clk, .rstN, .muxMode, .justMode, .cmdWrEn, .cmdWrAddr, .cmdWrData,
    .rdAddr, .rdData, .curIdx, .strobe, .entryEoq, .entryInternal,
    .entrySampleCode, .convKind, .convChan, .muxSel, .convData
  );

  assign sampleActive = strobe.sampleOn;
  assign convStart    = strobe.startConv;

endmodule

// File: rtl/scan_checker.sv
module scan_checker (
  input logic       clk,
  input logic       rstN,
  input logic       muxMode,
  input logic       sampleActive,
  input logic [2:0] muxSel,
  input logic       convStart,
  input logic [1:0] convKind,
  input logic [5:0] convChan
);

  logic [4:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (sampleActive) runLen <= runLen + 5'd1;
    else runLen <= '0;
  end

  assert_start_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_internal_nosample_R4: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && (convKind == 2'd2 || convKind == 2'd3)) |-> !$past(sampleActive));

  assert_direct_pins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && convKind == 2'd0 && !muxMode) |->
      (convChan <= 6'd3 || (convChan >= 6'd48 && convChan <= 6'd59)));

  assert_muxsel_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !muxMode |-> muxSel == 3'd0);

  assert_sample_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    sampleActive |-> runLen < 5'd16);

  assert_start_after_sample_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampleActive) |-> convStart);

endmodule

bind adc_scan_sequencer scan_checker chk (
  .clk(clk), .rstN(rstN), .muxMode(muxMode), .sampleActive(sampleActive),
  .muxSel(muxSel), .convStart(convStart), .convKind(convKind), .convChan(convChan)
);

// File: tb/adc_scan_sequencer_test.sv
module adc_scan_sequencer_test;

  localparam int QD = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scanEn = 1'b0, muxMode = 1'b0, cmdWrEn = 1'b0;
  logic [1:0] justMode = 2'd0;
  logic [IW-1:0] cmdWrAddr = '0, rdAddr = '0;
  logic [7:0] cmdWrData = '0;
  logic [15:0] rdData;
  logic sampleActive, convStart, convDone;
  logic [2:0] muxSel;
  logic [1:0] convKind;
  logic [5:0] convChan;
  logic [9:0] convData;

  int errors = 0, checks = 0, cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  adc_scan_sequencer #(.QDEPTH(QD)) uut (.*);

  // values the engine stub returns
  function automatic logic [9:0] engineValue(input logic [1:0] k, input logic [5:0] ch);
    case (k)
      2'd0: return 10'(ch * 13 + 7);
      2'd1: return 10'h011;
      2'd2: return 10'h3F0;
      default: return 10'h200;
    endcase
  endfunction

  function automatic logic [15:0] fmt(input logic [9:0] d, input logic [1:0] j);
    case (j)
      2'd1: return {~d[9], d[8:0], 6'b0};
      2'd2: return {d, 6'b0};
      default: return {6'b0, d};
    endcase
  endfunction

  // conversion engine stub and observers
  logic       pend = 1'b0;
  logic [1:0] waitCnt = '0;
  logic [9:0] pendVal = '0;
  logic [4:0] runCnt = '0, lastSamp = '0;
  logic [1:0] lastKind = '0;
  logic [5:0] lastChan = '0, prevChan = '0;
  logic [2:0] lastMux = '0;
  int startCnt = 0, cnt50 = 0, cntRestart = 0, cntWrap = 0;

  initial begin convDone = 1'b0; convData = '0; end

  always_ff @(posedge clk) begin
    convDone <= 1'b0;
    if (convStart) begin
      pend    <= 1'b1;
      waitCnt <= 2'd2;
      pendVal <= engineValue(convKind, convChan);
    end else if (pend) begin
      if (waitCnt == 2'd0) begin
        convDone <= 1'b1;
        convData <= pendVal;
        pend     <= 1'b0;
      end else waitCnt <= waitCnt - 2'd1;
    end
    if (sampleActive) runCnt <= runCnt + 5'd1;
    if (convStart) begin
      lastSamp <= runCnt;
      runCnt   <= '0;
      lastKind <= convKind;
      lastChan <= convChan;
      prevChan <= lastChan;
      lastMux  <= muxSel;
      startCnt <= startCnt + 1;
      if (convKind == 2'd0 && convChan == 6'd50) cnt50 <= cnt50 + 1;
      if (convKind == 2'd0 && lastChan == 6'd3 && convChan == 6'd2) cntRestart <= cntRestart + 1;
      if (convKind == 2'd0 && lastChan == 6'd55 && convChan == 6'd48) cntWrap <= cntWrap + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeCmd(input int addr, input logic [1:0] st, input logic [5:0] ch);
    @(negedge clk);
    cmdWrEn = 1'b1; cmdWrAddr = IW'(addr); cmdWrData = {st, ch};
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic stopScan();
    @(negedge clk);
    scanEn = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic waitDones(input int n);
    repeat (n) begin
      do @(negedge clk); while (!convDone);
    end
  endtask

  task automatic readRes(input int addr, output logic [15:0] v);
    rdAddr = IW'(addr);
    #1 v = rdData;
  endtask

  // {chan[17:12], st[11:10], mux[9], just[8:7], kind[6:5], samp[4:0]}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {6'd2,  2'd0, 1'b0, 2'd0, 2'd0, 5'd2},   // R6 direct pin
    {6'd5,  2'd1, 1'b0, 2'd0, 2'd1, 5'd4},   // R6 invalid in direct mode
    {6'd5,  2'd1, 1'b1, 2'd2, 2'd0, 5'd4},   // R6 R9 muxed pin
    {6'd60, 2'd3, 1'b0, 2'd0, 2'd1, 5'd0},   // R4 low ref
    {6'd61, 2'd2, 1'b0, 2'd1, 2'd2, 5'd0},   // R4 high ref
    {6'd62, 2'd0, 1'b1, 2'd1, 2'd3, 5'd0},   // R4 mid scale, signed zero R8
    {6'd40, 2'd2, 1'b1, 2'd2, 2'd1, 5'd8},   // R5 reserved
    {6'd50, 2'd3, 1'b0, 2'd1, 2'd0, 5'd16},  // R7 longest sample
    {6'd31, 2'd0, 1'b1, 2'd3, 2'd0, 5'd2},   // R8 code 3, R9
    {6'd31, 2'd0, 1'b0, 2'd0, 2'd1, 5'd2},   // R6 edge of invalid range
    {6'd47, 2'd1, 1'b0, 2'd0, 2'd1, 5'd4},   // R5 top of reserved
    {6'd59, 2'd0, 1'b1, 2'd2, 2'd0, 5'd2}    // R9 direct pin in mux mode
  };

  initial begin
    logic [15:0] v;
    int s0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < QD; a++) begin
      readRes(a, v);
      check(v == 16'h0, "R1 result reset", v, 0);
    end
    @(negedge clk); scanEn = 1'b1;
    repeat (30) @(negedge clk);
    check(startCnt == 0, "R1 empty queue starts nothing", startCnt, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [5:0] ch; logic [1:0] st, jm, ek; logic mx; logic [4:0] es;
      logic [2:0] em; logic [15:0] er;
      {ch, st, mx, jm, ek, es} = VEC[i];
      stopScan();
      muxMode = mx; justMode = jm;
      writeCmd(0, st, ch);
      writeCmd(1, 2'd0, 6'd63);
      scanEn = 1'b1;
      waitDones(2);
      @(negedge clk);
      er = fmt(engineValue(ek, ch), jm);
      em = (mx && ek == 2'd0 && ch < 6'd32) ? ch[2:0] : 3'd0;
      readRes(0, v);
      check(v == er, $sformatf("R8 R10 result vec%0d", i), v, er);
      check(lastKind == ek, $sformatf("R4 R5 R6 kind vec%0d", i), lastKind, ek);
      check(lastSamp == es, $sformatf("R7 sample len vec%0d", i), lastSamp, es);
      check(lastMux == em, $sformatf("R9 muxSel vec%0d", i), lastMux, em);
      check(lastChan == ((ek == 2'd0) ? ch : 6'd0), $sformatf("R6 chan vec%0d", i), lastChan, ch);
    end

    // R2: end marker restarts, entry after it never converted
    stopScan();
    muxMode = 1'b0; justMode = 2'd0;
    writeCmd(0, 2'd0, 6'd2);
    writeCmd(1, 2'd0, 6'd3);
    writeCmd(2, 2'd0, 6'd63);
    writeCmd(3, 2'd0, 6'd50);
    s0 = cntRestart;
    begin
      int c50;
      c50 = cnt50;
      scanEn = 1'b1;
      waitDones(8);
      @(negedge clk);
      check(cntRestart - s0 >= 3, "R2 restart after end marker", cntRestart - s0, 3);
      check(cnt50 == c50, "R2 entry past marker not converted", cnt50 - c50, 0);
    end
    readRes(3, v);
    check(v == 16'h0, "R2 result past marker untouched", v, 0);
    readRes(1, v);
    check(v == fmt(engineValue(2'd0, 6'd3), 2'd0), "R2 result entry1", v, fmt(engineValue(2'd0, 6'd3), 2'd0));

    // R3: full queue wraps from last index to 0
    stopScan();
    for (int e = 0; e < QD; e++) writeCmd(e, 2'd0, 6'(48 + e));
    s0 = cntWrap;
    scanEn = 1'b1;
    waitDones(20);
    @(negedge clk);
    check(cntWrap - s0 >= 1, "R3 wrap 55->48", cntWrap - s0, 1);
    readRes(QD - 1, v);
    check(v == fmt(engineValue(2'd0, 6'd55), 2'd0), "R3 last entry result", v, fmt(engineValue(2'd0, 6'd55), 2'd0));

    // R10: read of entry 0 in the same cycle as its write
    rdAddr = '0;
    @(negedge clk); justMode = 2'd2;
    do @(negedge clk); while (!(convDone && lastChan == 6'd48));
    readRes(0, v);
    check(v == fmt(engineValue(2'd0, 6'd48), 2'd0), "R10 old value in done cycle", v, fmt(engineValue(2'd0, 6'd48), 2'd0));
    @(negedge clk);
    readRes(0, v);
    check(v == fmt(engineValue(2'd0, 6'd48), 2'd2), "R10 new value after done", v, fmt(engineValue(2'd0, 6'd48), 2'd2));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule